// File: doc/BRIEF.md
# AEGIS-128 State Update Engine

This block keeps the 640-bit internal state of an AEGIS-128 authenticated cipher as five 128-bit words and advances it with the cipher's state-update function. Each update absorbs one 128-bit message word. Every state word passes through one keyless AES round, and each round result is folded into the next word around the ring. The surrounding datapath uses the block for two jobs. It absorbs associated data and message words one at a time. It also brings up a fresh state from a key and a nonce before any data is processed.

Commands arrive on one valid/ready port. A command either starts initialization with a key and an IV, or absorbs a single message word. An absorb completes in the clock edge that accepts it. An initialization first loads the state from the key, the IV and two fixed constants, then runs ten updates on its own, and keeps the port busy the whole time. The end of each command is marked by a one-cycle done pulse. The full state is always visible on a parallel read port, so keystream and tag logic outside the block can tap it directly.

Top module: `aegis_state_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, the read port shows all zeros, `cmd_ready` is 1 and `upd_done` is 0.
- R2: An absorb command (`cmd_init` = 0) accepted at an edge replaces the state, at that edge, with the update result. Using the old words S0..S4 and the message word m, the new words are S0^R(S4)^m, S1^R(S0), S2^R(S1), S3^R(S2) and S4^R(S3). `upd_done` is 1 in the following cycle.
- R3: R is an AES round with a zero round key. Output byte i of the row shift takes input byte (i + 4*(i mod 4)) mod 16, with bytes counted column by column. The AES S-box is then applied to every byte. Each column is then mixed with the MixColumns matrix, where doubling a byte is a left shift XOR 0x1B when the byte's top bit was set. As a result, R of an all-zero word is 0x63 in every byte.
- R4: In the cycle after an init command (`cmd_init` = 1) is accepted, the state is S0 = K^IV, S1 = B, S2 = A, S3 = K^A, S4 = K^B. A is 128'h6279e990593722150d08050302010100 and B is 128'hdd28b57342311120f12fc26d55183ddb.
- R5: After that load, ten updates run on consecutive edges. The absorbed words alternate K, K^IV, K, ... and end with K^IV. `upd_done` is 0 in the ten cycles after the load and 1 in the eleventh cycle after acceptance.
- R6: `cmd_ready` is 0 from the load cycle through the cycle before `upd_done`. Commands presented while it is 0 leave the state unchanged.
- R7: `upd_done` is a single-cycle pulse unless another absorb is accepted in the cycle it is high. The state holds its value in any cycle where no command is accepted and no initialization is running.
- R8: State word i appears on `state_rd[128*i+127:128*i]`. Byte 0 of every word, including key, IV and message, sits in bits [7:0].
- R9: Absorb commands held valid on consecutive cycles are each accepted and applied in turn, one per cycle, with `upd_done` high after each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_init | input | 1 | 1 = initialize from key and IV, 0 = absorb one word |
| cmd_key | input | 128 | Key for initialization |
| cmd_iv | input | 128 | IV for initialization |
| cmd_msg | input | 128 | Message word for an absorb |
| upd_done | output | 1 | One-cycle pulse after a command completes |
| state_rd | output | 640 | The five state words, S0 in the low bits |

## Verification
The hardest situation to reach from the ports is a command offered while initialization runs. In that state the port must refuse the word, and the ten-step sequence must keep feeding its own key words whatever appears on the message input. The stimulus holds an absorb request valid with a random message across the whole busy window of one initialization. It then compares the final state with a bench model that never saw that word. Back-to-back absorb bursts and an all-zero start state add a directed check of the round constant 0x63, alongside seeded random keys, IVs and messages.

// File: rtl/aegis_pkg.sv
package aegis_pkg;

    localparam int WORD_W     = 128;
    localparam int NUM_WORDS  = 5;
    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = WORD_W / BYTE_W;
    localparam int COL_BYTES  = 4;
    localparam int NUM_COLS   = NUM_BYTES / COL_BYTES;
    localparam int INIT_STEPS = 10;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_INIT = 1'b1
    } phase_e;

    // Fixed initialization words, byte 0 in bits [7:0]
    localparam word_t CONST_A = 128'h6279e990_59372215_0d080503_02010100;
    localparam word_t CONST_B = 128'hdd28b573_42311120_f12fc26d_55183ddb;

    function automatic byte_t gf_dbl(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 by square-and-multiply, then the affine map
    function automatic byte_t sbox_calc(input byte_t a);
        byte_t p;
        byte_t r;
        p = a;
        r = 8'h01;
        for (int k = 0; k < 7; k++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
                 ^ {r[3:0], r[7:4]} ^ 8'h63;
    endfunction

endpackage

// File: rtl/aegis_sbox_unit.sv
module aegis_sbox_unit
    import aegis_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    assign dout = sbox_calc(din);
endmodule

// File: rtl/aegis_round_unit.sv
module aegis_round_unit
    import aegis_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    byte_t shifted [NUM_BYTES];
    byte_t subbed  [NUM_BYTES];

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        localparam int SRC = (i + COL_BYTES * (i % COL_BYTES)) % NUM_BYTES;
        assign shifted[i] = din[BYTE_W*SRC +: BYTE_W];
        aegis_sbox_unit u_sbox (
            .din  (shifted[i]),
            .dout (subbed[i])
        );
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        byte_t b0, b1, b2, b3;
        assign b0 = subbed[COL_BYTES*c + 0];
        assign b1 = subbed[COL_BYTES*c + 1];
        assign b2 = subbed[COL_BYTES*c + 2];
        assign b3 = subbed[COL_BYTES*c + 3];
        assign dout[BYTE_W*(COL_BYTES*c+0) +: BYTE_W] = gf_dbl(b0) ^ gf_dbl(b1) ^ b1 ^ b2 ^ b3;
        assign dout[BYTE_W*(COL_BYTES*c+1) +: BYTE_W] = b0 ^ gf_dbl(b1) ^ gf_dbl(b2) ^ b2 ^ b3;
        assign dout[BYTE_W*(COL_BYTES*c+2) +: BYTE_W] = b0 ^ b1 ^ gf_dbl(b2) ^ gf_dbl(b3) ^ b3;
        assign dout[BYTE_W*(COL_BYTES*c+3) +: BYTE_W] = gf_dbl(b0) ^ b0 ^ b1 ^ b2 ^ gf_dbl(b3);
    end
endmodule

// File: rtl/aegis_update_unit.sv
module aegis_update_unit
    import aegis_pkg::*;
(
    input  logic [NUM_WORDS*WORD_W-1:0] st_in,
    input  logic [WORD_W-1:0]           msg,
    output logic [NUM_WORDS*WORD_W-1:0] st_out
);
    word_t rnd [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        aegis_round_unit u_round (
            .din  (st_in[WORD_W*i +: WORD_W]),
            .dout (rnd[i])
        );
        if (i == 0) begin : g_head
            assign st_out[0 +: WORD_W] = st_in[0 +: WORD_W] ^ rnd[NUM_WORDS-1] ^ msg;
        end else begin : g_tail
            assign st_out[WORD_W*i +: WORD_W] = st_in[WORD_W*i +: WORD_W] ^ rnd[i-1];
        end
    end
endmodule

// File: rtl/aegis_state_engine.sv
module aegis_state_engine
    import aegis_pkg::*;
#(
    parameter int STEPS = INIT_STEPS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic                        cmd_init,
    input  logic [WORD_W-1:0]           cmd_key,
    input  logic [WORD_W-1:0]           cmd_iv,
    input  logic [WORD_W-1:0]           cmd_msg,
    output logic                        upd_done,
    output logic [NUM_WORDS*WORD_W-1:0] state_rd
);
    localparam int                CNT_W = $clog2(STEPS + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] st;
        word_t                            key;
        word_t                            kiv;
        logic [CNT_W-1:0]                 cnt;
        phase_e                           phase;
        logic                             done;
    } regs_t;

    regs_t q, d;
    word_t upd_msg;
    logic [NUM_WORDS*WORD_W-1:0] upd_next;

    aegis_update_unit u_update (
        .st_in  (q.st),
        .msg    (upd_msg),
        .st_out (upd_next)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.phase == PH_INIT) begin
            upd_msg = q.cnt[0] ? q.kiv : q.key;
        end else begin
            upd_msg = cmd_msg;
        end
        case (q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_init) begin
                        d.key   = cmd_key;
                        d.kiv   = cmd_key ^ cmd_iv;
                        d.st[0] = cmd_key ^ cmd_iv;
                        d.st[1] = CONST_B;
                        d.st[2] = CONST_A;
                        d.st[3] = cmd_key ^ CONST_A;
                        d.st[4] = cmd_key ^ CONST_B;
                        d.cnt   = '0;
                        d.phase = PH_INIT;
                    end else begin
                        d.st   = upd_next;
                        d.done = 1'b1;
                    end
                end
            end
            default: begin
                d.st = upd_next;
                if (q.cnt == LAST) begin
                    d.cnt   = '0;
                    d.phase = PH_IDLE;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.phase == PH_IDLE);
    assign upd_done  = q.done;
    assign state_rd  = q.st;
endmodule

// File: rtl/aegis_state_engine_chk.sv
module aegis_state_engine_chk
    import aegis_pkg::*;
#(
    parameter int STEPS = INIT_STEPS
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic                        cmd_init,
    input logic                        upd_done,
    input logic [NUM_WORDS*WORD_W-1:0] state_rd
);
    localparam int CW = $clog2(STEPS + 2);
    localparam logic [CW-1:0] END_CNT = CW'(STEPS + 1);
    localparam logic [CW-1:0] MAX_BUSY = CW'(STEPS);

    logic [CW-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (cmd_valid && cmd_ready && cmd_init) begin
            busy_q <= CW'(1);
        end else if (busy_q != '0 && busy_q <= MAX_BUSY) begin
            busy_q <= busy_q + 1'b1;
        end else begin
            busy_q <= '0;
        end
    end

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0 && busy_q <= MAX_BUSY) |-> !cmd_ready);

    // R5
    init_no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0 && busy_q <= MAX_BUSY) |-> !upd_done);

    // R5
    init_done_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q == END_CNT) |-> upd_done);

    // R2
    absorb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_init) |=> upd_done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !(cmd_valid && cmd_ready && !cmd_init)) |=> !upd_done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> $stable(state_rd));
endmodule

bind aegis_state_engine aegis_state_engine_chk #(.STEPS(STEPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_init  (cmd_init),
    .upd_done  (upd_done),
    .state_rd  (state_rd)
);

// File: tb/sim_aegis_state_engine.sv
`timescale 1ns/1ps
module sim_aegis_state_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic         cmd_init = 1'b0;
    logic [127:0] cmd_key = '0;
    logic [127:0] cmd_iv = '0;
    logic [127:0] cmd_msg = '0;
    logic         upd_done;
    logic [639:0] state_rd;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0]   sbt [256];
    logic [127:0] ms  [5];

    always #10 clk = ~clk;

    aegis_state_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_init  (cmd_init),
        .cmd_key   (cmd_key),
        .cmd_iv    (cmd_iv),
        .cmd_msg   (cmd_msg),
        .upd_done  (upd_done),
        .state_rd  (state_rd)
    );

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return r;
    endfunction

    // S-box by brute-force inverse search and bitwise affine map
    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] y;
            for (int c = 1; c < 256; c++) begin
                if (gm(8'(x), 8'(c)) == 8'h01) inv = 8'(c);
            end
            for (int i = 0; i < 8; i++) begin
                y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
            end
            sbt[x] = y;
        end
    endtask

    function automatic logic [127:0] rref(input logic [127:0] w);
        logic [127:0] o;
        logic [7:0] a [4];
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                a[r] = sbt[w[8*(4*((c+r)%4)+r) +: 8]];
            end
            for (int r = 0; r < 4; r++) begin
                o[8*(4*c+r) +: 8] = gm(8'h02, a[r]) ^ gm(8'h03, a[(r+1)%4])
                                  ^ a[(r+2)%4] ^ a[(r+3)%4];
            end
        end
        return o;
    endfunction

    task automatic model_update(input logic [127:0] m);
        logic [127:0] o [5];
        o[0] = ms[0] ^ rref(ms[4]) ^ m;
        for (int i = 1; i < 5; i++) o[i] = ms[i] ^ rref(ms[i-1]);
        for (int i = 0; i < 5; i++) ms[i] = o[i];
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        for (int i = 0; i < 5; i++) begin
            chk(state_rd[128*i +: 128] === ms[i], req, state_rd[128*i +: 128], ms[i]);
        end
    endtask

    task automatic absorb_burst(input int n, input bit zero_msg);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            cmd_valid = 1'b1;
            cmd_init  = 1'b0;
            cmd_msg   = zero_msg ? '0 : rnd128();
            @(posedge clk);
            model_update(cmd_msg);
            @(negedge clk);
            chk(upd_done === 1'b1, "R2", 128'(upd_done), 128'd1);
            check_state(n > 1 ? "R9" : "R2");
        end
        cmd_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(upd_done === 1'b0, "R7", 128'(upd_done), 128'd0);
        check_state("R7");
    endtask

    task automatic do_init(input logic [127:0] k, input logic [127:0] iv, input bit poke);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_init  = 1'b1;
        cmd_key   = k;
        cmd_iv    = iv;
        @(posedge clk);
        ms[0] = k ^ iv;
        ms[1] = 128'hdd28b573_42311120_f12fc26d_55183ddb;
        ms[2] = 128'h6279e990_59372215_0d080503_02010100;
        ms[3] = k ^ ms[2];
        ms[4] = k ^ ms[1];
        @(negedge clk);
        cmd_valid = poke;
        cmd_init  = 1'b0;
        cmd_msg   = rnd128();
        chk(cmd_ready === 1'b0, "R6", 128'(cmd_ready), 128'd0);
        check_state("R4");
        for (int j = 1; j <= 10; j++) begin
            @(posedge clk);
            model_update((j % 2 == 1) ? k : (k ^ iv));
            @(negedge clk);
            if (j < 10) begin
                chk(upd_done === 1'b0, "R5", 128'(upd_done), 128'd0);
                chk(cmd_ready === 1'b0, "R6", 128'(cmd_ready), 128'd0);
            end else begin
                chk(upd_done === 1'b1, "R5", 128'(upd_done), 128'd1);
                chk(cmd_ready === 1'b1, "R5", 128'(cmd_ready), 128'd1);
            end
        end
        cmd_valid = 1'b0;
        check_state(poke ? "R6" : "R5");
        @(posedge clk);
        @(negedge clk);
        chk(upd_done === 1'b0, "R7", 128'(upd_done), 128'd0);
        check_state("R7");
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_sbox();
        for (int i = 0; i < 5; i++) ms[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: during reset
        chk(cmd_ready === 1'b1, "R1", 128'(cmd_ready), 128'd1);
        chk(upd_done === 1'b0, "R1", 128'(upd_done), 128'd0);
        check_state("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(upd_done === 1'b0, "R1", 128'(upd_done), 128'd0);
        check_state("R1");

        // R3: zero message on zero state gives 0x63 in every byte of S1..S4
        absorb_burst(1, 1'b1);
        chk(state_rd[128 +: 128] === {16{8'h63}}, "R3", state_rd[128 +: 128], {16{8'h63}});
        chk(state_rd[0 +: 128] === {16{8'h63}}, "R3", state_rd[0 +: 128], {16{8'h63}});
        // R8: word 4 in the top slice
        chk(state_rd[512 +: 128] === {16{8'h63}}, "R8", state_rd[512 +: 128], {16{8'h63}});

        // R4, R5: all-zero key and IV
        do_init('0, '0, 1'b0);
        absorb_burst(1, 1'b0);

        // Random initializations; R6: absorb offered while busy
        do_init(rnd128(), rnd128(), 1'b0);
        absorb_burst(3, 1'b0);
        do_init(rnd128(), rnd128(), 1'b1);
        absorb_burst(2, 1'b0);
        do_init({16{8'hff}}, {16{8'h5a}}, 1'b1);

        // R9: random bursts with gaps
        for (int b = 0; b < 12; b++) begin
            absorb_burst(1 + int'($urandom % 5), 1'b0);
            repeat ($urandom % 3) @(posedge clk);
        end

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule